// File: doc/BRIEF.md
# Register-File ALU Datapath

This block is a single-cycle datapath built around a small register file. Two read ports select any two of the four registers. Each read port is a bank of one-bit multiplexers that share one select. The two selected words feed an eight-function ALU built from chained bit slices. On a rising clock edge with the write enable high, the ALU result goes through a one-hot destination decoder into exactly one register. In the same edge, the zero and carry status is captured in a separate flags register.

The block takes one operation per clock with no back-pressure. The select, operation and enable inputs are plain control pins, sampled on every rising edge, and there is no valid/ready handshake because the datapath never stalls. All register contents and both flags are driven out continuously. A controller can observe the state directly and chain operations cycle after cycle. The block has no immediate-data input, so constants are built from the reset value with the ALU itself (for example, NOT of a zero register gives 8'hFF).

Top module: `rf_alu_datapath`

## Requirements
- R1: While `rst_n` is low, all four registers and both flags are 0; reset is asynchronous and active low.
- R2: Operand A is the register numbered by `src_a_sel` and operand B the register numbered by `src_b_sel`; the two selects are independent and may name the same register.
- R3: On a rising edge with `wr_en` high, the ALU result is written into the register numbered by `dst_sel` and no other register changes.
- R4: On a rising edge with `wr_en` low, no register and neither flag changes, whatever the other inputs are.
- R5: The `op` codes are: 0 A AND B, 1 A OR B, 2 NOT A, 3 B, 4 A+B mod 256, 5 A-B mod 256, 6 A XOR B, 7 A.
- R6: On a write, `flag_carry` becomes the carry out of A+B for op 4, becomes 1 exactly when A >= B (unsigned, no borrow) for op 5, and becomes 0 for every other op.
- R7: On a write, `flag_zero` becomes 1 exactly when the written result is 8'h00.
- R8: Reads are combinational, so a register that is both a source and the destination supplies its old value, and the new value is visible on `reg_q` from the following cycle.
- R9: Register n appears on `reg_q[8n+7:8n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a_sel | input | 2 | Register number for operand A |
| src_b_sel | input | 2 | Register number for operand B |
| dst_sel | input | 2 | Register number that receives the result |
| op | input | 3 | ALU function code |
| wr_en | input | 1 | Enables the write of result and flags at the edge |
| reg_q | output | 32 | All four registers, register n in bits [8n+7:8n] |
| flag_zero | output | 1 | Stored zero status of the last write |
| flag_carry | output | 1 | Stored carry status of the last write |

## Verification
Every piece of state is a port here, so a register written with the wrong value, written at the wrong address or disturbed when it should hold shows on `reg_q` in the cycle right after the faulty edge. A wrong operand select or a wrong function is not visible by itself. It shows once its result lands in a register: one cycle later, or several cycles later when a corrupted register is read again as a source. Flag errors show on the flag pins after the same single edge. A flag that updates while `wr_en` is low is caught on the first idle cycle that follows a write with a different status.

// File: rtl/dp_pkg.sv
package dp_pkg;

  typedef enum logic [2:0] {
    OP_AND   = 3'd0,
    OP_OR    = 3'd1,
    OP_NOTA  = 3'd2,
    OP_PASSB = 3'd3,
    OP_ADD   = 3'd4,
    OP_SUB   = 3'd5,
    OP_XOR   = 3'd6,
    OP_PASSA = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic zero;
    logic carry;
  } flags_t;

  function automatic logic op_is_arith(alu_op_e o);
    return (o == OP_ADD) || (o == OP_SUB);
  endfunction

endpackage

// File: rtl/dp_alu_slice.sv
module dp_alu_slice
  import dp_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    cin_i,
  input  logic    inv_b_i,
  input  alu_op_e op_i,
  output logic    res_o,
  output logic    cout_o
);
  logic b_eff;
  logic sum;

  assign b_eff  = b_i ^ inv_b_i;
  assign sum    = a_i ^ b_eff ^ cin_i;
  assign cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);

  always_comb begin
    unique case (op_i)
      OP_AND:   res_o = a_i & b_i;
      OP_OR:    res_o = a_i | b_i;
      OP_NOTA:  res_o = ~a_i;
      OP_PASSB: res_o = b_i;
      OP_ADD:   res_o = sum;
      OP_SUB:   res_o = sum;
      OP_XOR:   res_o = a_i ^ b_i;
      OP_PASSA: res_o = a_i;
      default:  res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_op_e          op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o
);
  logic [WIDTH:0] chain;
  logic           is_sub;

  assign is_sub   = (op_i == OP_SUB);
  assign chain[0] = is_sub;

  for (genvar k = 0; k < WIDTH; k++) begin : g_slice
    dp_alu_slice u_slice (
      .a_i     (a_i[k]),
      .b_i     (b_i[k]),
      .cin_i   (chain[k]),
      .inv_b_i (is_sub),
      .op_i    (op_i),
      .res_o   (res_o[k]),
      .cout_o  (chain[k+1])
    );
  end

  assign carry_o = op_is_arith(op_i) ? chain[WIDTH] : 1'b0;
endmodule

// File: rtl/dp_read_mux.sv
module dp_read_mux #(
  parameter int WIDTH = 8,
  parameter int NREGS = 4,
  localparam int SELW = $clog2(NREGS)
) (
  input  logic [NREGS*WIDTH-1:0] regs_i,
  input  logic [SELW-1:0]        sel_i,
  output logic [WIDTH-1:0]       q_o
);
  for (genvar j = 0; j < WIDTH; j++) begin : g_bit
    logic [NREGS-1:0] column;
    for (genvar i = 0; i < NREGS; i++) begin : g_src
      assign column[i] = regs_i[i*WIDTH + j];
    end
    assign q_o[j] = column[sel_i];
  end
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int WIDTH = 8,
  parameter int NREGS = 4,
  localparam int SELW = $clog2(NREGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [SELW-1:0]        dst_i,
  input  logic [WIDTH-1:0]       wdata_i,
  output logic [NREGS*WIDTH-1:0] regs_o
);
  logic [NREGS-1:0] row_we;

  always_comb begin
    row_we = '0;
    if (wr_en_i) row_we[dst_i] = 1'b1;
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_row
    logic [WIDTH-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         word_q <= '0;
      else if (row_we[i]) word_q <= wdata_i;
    end
    assign regs_o[i*WIDTH +: WIDTH] = word_q;
  end
endmodule

// File: rtl/rf_alu_datapath.sv
module rf_alu_datapath
  import dp_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NREGS = 4,
  localparam int SELW = $clog2(NREGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SELW-1:0]        src_a_sel,
  input  logic [SELW-1:0]        src_b_sel,
  input  logic [SELW-1:0]        dst_sel,
  input  logic [2:0]             op,
  input  logic                   wr_en,
  output logic [NREGS*WIDTH-1:0] reg_q,
  output logic                   flag_zero,
  output logic                   flag_carry
);
  logic [WIDTH-1:0] opnd_a;
  logic [WIDTH-1:0] opnd_b;
  logic [WIDTH-1:0] alu_res;
  logic             alu_carry;
  alu_op_e          op_e;
  flags_t           flags_q;

  assign op_e = alu_op_e'(op);

  dp_read_mux #(.WIDTH(WIDTH), .NREGS(NREGS)) u_mux_a (
    .regs_i (reg_q),
    .sel_i  (src_a_sel),
    .q_o    (opnd_a)
  );

  dp_read_mux #(.WIDTH(WIDTH), .NREGS(NREGS)) u_mux_b (
    .regs_i (reg_q),
    .sel_i  (src_b_sel),
    .q_o    (opnd_b)
  );

  dp_alu #(.WIDTH(WIDTH)) u_alu (
    .a_i     (opnd_a),
    .b_i     (opnd_b),
    .op_i    (op_e),
    .res_o   (alu_res),
    .carry_o (alu_carry)
  );

  dp_regfile #(.WIDTH(WIDTH), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en),
    .dst_i   (dst_sel),
    .wdata_i (alu_res),
    .regs_o  (reg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (wr_en) begin
      flags_q.zero  <= (alu_res == '0);
      flags_q.carry <= alu_carry;
    end
  end

  assign flag_zero  = flags_q.zero;
  assign flag_carry = flags_q.carry;
endmodule

// File: rtl/dp_datapath_chk.sv
module dp_datapath_chk #(
  parameter int WIDTH = 8,
  parameter int NREGS = 4,
  localparam int SELW = $clog2(NREGS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [SELW-1:0]        dst_sel,
  input logic                   wr_en,
  input logic [NREGS*WIDTH-1:0] reg_q,
  input logic                   flag_zero,
  input logic                   flag_carry,
  input logic [WIDTH-1:0]       alu_res
);
  logic [WIDTH-1:0] word [NREGS];
  for (genvar i = 0; i < NREGS; i++) begin : g_unpack
    assign word[i] = reg_q[i*WIDTH +: WIDTH];
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (reg_q == '0) && !flag_zero && !flag_carry);

  p_write_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (word[$past(dst_sel)] == $past(alu_res)));

  for (genvar i = 0; i < NREGS; i++) begin : g_hold
    p_others_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || (dst_sel != SELW'(i))) |=> $stable(word[i]));
  end

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_q) && $stable(flag_zero) && $stable(flag_carry));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (flag_zero == (word[$past(dst_sel)] == '0)));
endmodule

bind rf_alu_datapath dp_datapath_chk #(.WIDTH(WIDTH), .NREGS(NREGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dst_sel    (dst_sel),
  .wr_en      (wr_en),
  .reg_q      (reg_q),
  .flag_zero  (flag_zero),
  .flag_carry (flag_carry),
  .alu_res    (alu_res)
);

// File: tb/rf_alu_datapath_tb.sv
`timescale 1ns/1ps
module rf_alu_datapath_tb;
  localparam int W = 8;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   src_a_sel = '0, src_b_sel = '0, dst_sel = '0;
  logic [2:0]   op = '0;
  logic         wr_en = 1'b0;
  logic [N*W-1:0] reg_q;
  logic         flag_zero, flag_carry;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  logic [7:0] m_reg [N];
  bit m_z, m_c;

  always #5 clk = ~clk;

  rf_alu_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .src_a_sel(src_a_sel), .src_b_sel(src_b_sel),
    .dst_sel(dst_sel), .op(op), .wr_en(wr_en), .reg_q(reg_q),
    .flag_zero(flag_zero), .flag_carry(flag_carry)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Behavioural model of the function table (R5) and carry rule (R6).
  task automatic model_op(input int o, input int a, input int b,
                          output int r, output bit c);
    c = 0;
    case (o)
      0: r = a & b;
      1: r = a | b;
      2: r = (~a) & 255;
      3: r = b;
      4: begin r = (a + b) & 255; c = ((a + b) > 255); end
      5: begin r = (a - b) & 255; c = (a >= b); end
      6: r = a ^ b;
      default: r = a;
    endcase
  endtask

  task automatic compare_all(input string tag);
    for (int i = 0; i < N; i++) check(tag, reg_q[i*W +: W], m_reg[i]);
    check(tag, flag_zero, m_z);
    check(tag, flag_carry, m_c);
  endtask

  task automatic apply(input int a, input int b, input int d, input int o,
                       input bit we, input string tag);
    int r;
    bit c;
    src_a_sel = 2'(a); src_b_sel = 2'(b); dst_sel = 2'(d);
    op = 3'(o); wr_en = we;
    if (we) begin
      model_op(o, m_reg[a], m_reg[b], r, c);   // old values read (R8)
      m_reg[d] = 8'(r);
      m_z = (r == 0);
      m_c = c;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R3 watchdog: got 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_reg[i] = 8'h00;
    m_z = 0; m_c = 0;
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after release");

    apply(0, 0, 1, 2, 1, "R5 NOT");
    check("R9 r1 in bits 15:8", reg_q[15:8], 8'hFF);
    apply(0, 1, 2, 5, 1, "R6 sub borrow");
    check("R6 0-FF", reg_q[23:16], 8'h01);
    check("R6 borrow carry", flag_carry, 0);
    apply(1, 2, 3, 4, 1, "R6 add wrap");
    check("R6 FF+1", reg_q[31:24], 8'h00);
    check("R6 add carry", flag_carry, 1);
    check("R7 zero set", flag_zero, 1);
    apply(1, 2, 0, 4, 0, "R4 idle");
    check("R4 r0 unchanged", reg_q[7:0], 8'h00);
    check("R4 flags kept", flag_zero, 1);
    apply(2, 2, 2, 4, 1, "R8 self add");
    check("R8 1+1", reg_q[23:16], 8'h02);
    apply(1, 2, 0, 6, 1, "R2 xor");
    check("R2 FF^02", reg_q[7:0], 8'hFD);
    apply(1, 1, 3, 5, 1, "R6 sub equal");
    check("R6 equal no borrow", flag_carry, 1);
    check("R7 equal zero", flag_zero, 1);
    apply(0, 2, 1, 0, 1, "R5 and");
    check("R5 FD&02", reg_q[15:8], 8'h00);

    for (int n = 0; n < 600; n++) begin
      apply($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 7), ($urandom_range(0, 3) != 0), "R3 R5 random");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule